// File: doc/BRIEF.md
# Keyed Flash Program and Erase Controller

This block sits between a processor's register bus and a word-organised nonvolatile program array. It performs two operations: it erases one page, or it programs one row. Software first picks the operation in a control register by setting an operation code, an erase flag and a write-enable flag. It then gives the target by writing to the table port. For an erase, one dummy write to any word of a page selects that page. For a program, a row's worth of table writes fills a row latch and also names the row. The operation starts only if a two-write key reaches the key register immediately before the write that sets the start bit.

While an operation runs, the stall output holds the requester for a fixed, parameterised number of cycles. All register and table writes are ignored during that time. When the count ends, the array is updated and the start bit clears itself. A behavioural array stub with a read port stands in for the flash cells.

Top module: `flash_nvm_top`

## Requirements
- R1: After reset, the control readback is 0x0000, stall is low and every array word reads 0.
- R2: A control write (register select 0) while idle stores the operation code in bits 3:0, the erase flag in bit 6 and write enable in bit 14. Reserved bits read back as 0.
- R3: A key write (register select 1) of 0x0055, then a key write of 0x00AA, then a control write with bit 15 set starts the operation. Stall rises, and bit 15 reads 1 while the operation runs.
- R4: The start is ignored if the keys come in the wrong order, or if a different value replaces either key. In that case stall stays low, no error is raised and the array is unchanged. A 0x0055 key write always restarts the key sequence, so 0x55, 0x55, 0xAA is a valid unlock.
- R5: Any register or table write between the 0xAA key write and the start write cancels the unlock.
- R6: Stall stays high for exactly OpLatency cycles. Bit 15 then reads 0.
- R7: Opcode 0010 with the erase flag and write enable both set erases a page. All 512 words of the page that holds the latest table-write address become 0xFFFFFF, and other pages keep their contents.
- R8: Opcode 0001 with the erase flag clear and write enable set programs a row. The 64 latched words go into the row given by the latest table-write address: the page comes from address bits 9:9, the row from bits 8:6, and the latch slot from bits 5:0. Other rows are unchanged.
- R9: An unlocked start is rejected in three cases: write enable is clear, the operation code is undefined, or the erase flag does not match the code. A rejected start does not stall or touch the array, and it sets a sticky error flag in bit 13. Writing a control word with bit 13 set clears the flag.
- R10: While stalled, control, key and table writes have no effect.
- R11: Each start attempt uses up the unlock. A second start needs a new key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects control, 1 selects key |
| regWdata | input | 16 | Register write data |
| tblWe | input | 1 | Table write strobe |
| tblAddr | input | 10 | Table write word address |
| tblWdata | input | 24 | Table write data word |
| ctrlRead | output | 16 | Control register readback |
| stall | output | 1 | Requester stall, high while an operation runs |
| arrRdAddr | input | 10 | Array read address |
| arrRdData | output | 24 | Array read data |

## Verification
The bench tries broken key orders, a doubled first key, and writes slipped in after the second key. A design that tracked the keys loosely would start on those sequences, and stall would rise where it must stay low. It writes keys, control and latch data during a stall. A design that let those through would change the readback, start again without a fresh key, or copy the intruding latch word into the row. It times the stall to the exact cycle, and it checks the words at a page's edge and in the rows on either side of the programmed one. That catches an off-by-one counter and a wrong row or page decode. Rejected starts must leave the error bit set and the array untouched.

// File: rtl/flash_nvm_pkg.sv
package flash_nvm_pkg;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_FIRST = 2'd1,
    UNL_ARMED = 2'd2
  } unlockState_t;

  typedef struct packed {
    logic doErase;
    logic doProgram;
  } nvmStrobe_t;

  localparam logic [3:0]  OP_ROW_PROG   = 4'b0001;
  localparam logic [3:0]  OP_PAGE_ERASE = 4'b0010;
  localparam logic [15:0] KEY_FIRST     = 16'h0055;
  localparam logic [15:0] KEY_SECOND    = 16'h00AA;

  localparam int BIT_START = 15;
  localparam int BIT_WREN  = 14;
  localparam int BIT_ERR   = 13;
  localparam int BIT_ERASE = 6;

endpackage

// File: rtl/flash_nvm_ctrl.sv
module flash_nvm_ctrl
  import flash_nvm_pkg::*;
#(
  parameter int OpLatency = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regSel,
  input  logic [15:0] regWdata,
  input  logic        tblWe,
  output logic [15:0] ctrlRead,
  output logic        busy,
  output nvmStrobe_t  strobe
);

  localparam int CntW = $clog2(OpLatency + 1);

  unlockState_t   unlockQ, unlockD;
  logic [3:0]     opQ;
  logic           eraseQ, wrenQ, errQ, busyQ;
  logic [CntW-1:0] cntQ;

  logic wrCtl, wrKey, tblAct, startTry, opOk;
  logic [3:0] newOp;
  logic newErase, newWren;

  assign wrCtl  = regWe && !regSel && !busyQ;
  assign wrKey  = regWe &&  regSel && !busyQ;
  assign tblAct = tblWe && !busyQ;

  assign newOp    = regWdata[3:0];
  assign newErase = regWdata[BIT_ERASE];
  assign newWren  = regWdata[BIT_WREN];

  assign startTry = wrCtl && regWdata[BIT_START] && (unlockQ == UNL_ARMED);
  assign opOk = newWren &&
                (((newOp == OP_PAGE_ERASE) &&  newErase) ||
                 ((newOp == OP_ROW_PROG)   && !newErase));

  // unlock tracker: any non-matching write drops back to idle
  always_comb begin
    unlockD = unlockQ;
    if (wrKey) begin
      if (regWdata == KEY_FIRST)
        unlockD = UNL_FIRST;
      else if (unlockQ == UNL_FIRST && regWdata == KEY_SECOND)
        unlockD = UNL_ARMED;
      else
        unlockD = UNL_IDLE;
    end else if (wrCtl || tblAct) begin
      unlockD = UNL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlockQ <= UNL_IDLE;
    else       unlockQ <= unlockD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      eraseQ <= 1'b0;
      wrenQ  <= 1'b0;
      errQ   <= 1'b0;
      busyQ  <= 1'b0;
      cntQ   <= '0;
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end else if (wrCtl) begin
      opQ    <= newOp;
      eraseQ <= newErase;
      wrenQ  <= newWren;
      if (regWdata[BIT_ERR]) errQ <= 1'b0;
      if (startTry) begin
        if (opOk) begin
          busyQ <= 1'b1;
          cntQ  <= CntW'(OpLatency - 1);
        end else begin
          errQ <= 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign strobe.doErase   = busyQ && (cntQ == '0) && (opQ == OP_PAGE_ERASE);
  assign strobe.doProgram = busyQ && (cntQ == '0) && (opQ == OP_ROW_PROG);
  assign ctrlRead = {busyQ, wrenQ, errQ, 6'b0, eraseQ, 2'b0, opQ};

  assert_start_keyed_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> ($past(unlockQ) == UNL_ARMED));

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0) |=> busyQ);

  assert_stall_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ == '0) |=> !busyQ);

  assert_fields_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ($stable(opQ) && $stable(wrenQ) && $stable(eraseQ)));

  assert_err_no_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> !busyQ);

endmodule

// File: rtl/flash_nvm_datapath.sv
module flash_nvm_datapath #(
  parameter int AddrW    = 10,
  parameter int RowWords = 64,
  parameter int WordW    = 24
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tblWe,
  input  logic [AddrW-1:0]                 tblAddr,
  input  logic [WordW-1:0]                 tblWdata,
  input  logic                             stall,
  output logic [RowWords-1:0][WordW-1:0]   rowLatch,
  output logic [AddrW-1:0]                 tgtAddr
);

  localparam int RowBits = $clog2(RowWords);

  logic tblAct;
  assign tblAct = tblWe && !stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       tgtAddr <= '0;
    else if (tblAct) tgtAddr <= tblAddr;
  end

  for (genvar s = 0; s < RowWords; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rowLatch[s] <= '0;
      else if (tblAct && tblAddr[RowBits-1:0] == RowBits'(s))
        rowLatch[s] <= tblWdata;
    end
  end

  assert_target_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(tgtAddr));

endmodule

// File: rtl/flash_array_stub.sv
module flash_array_stub
  import flash_nvm_pkg::*;
#(
  parameter int NumPages = 2,
  parameter int PageRows = 8,
  parameter int RowWords = 64,
  parameter int WordW    = 24
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  nvmStrobe_t                     strobe,
  input  logic [AddrW-1:0]               tgtAddr,
  input  logic [RowWords-1:0][WordW-1:0] rowLatch,
  input  logic [AddrW-1:0]               rdAddr,
  output logic [WordW-1:0]               rdData
);

  localparam int PageWords = PageRows * RowWords;
  localparam int Words     = NumPages * PageWords;
  localparam int AddrW     = $clog2(Words);
  localparam int RowBits   = $clog2(RowWords);
  localparam int PageBits  = $clog2(PageWords);

  logic [WordW-1:0] mem [Words];

  for (genvar w = 0; w < Words; w++) begin : g_word
    localparam int PageIdx = w / PageWords;
    localparam int RowIdx  = w / RowWords;
    localparam int SlotIdx = w % RowWords;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[w] <= '0;
      else if (strobe.doErase && int'(tgtAddr >> PageBits) == PageIdx)
        mem[w] <= '1;
      else if (strobe.doProgram && int'(tgtAddr >> RowBits) == RowIdx)
        mem[w] <= rowLatch[SlotIdx];
    end
  end

  assign rdData = mem[rdAddr];

  assert_single_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doErase, strobe.doProgram}));

endmodule

// File: rtl/flash_nvm_top.sv
module flash_nvm_top
  import flash_nvm_pkg::*;
#(
  parameter int WordW     = 24,
  parameter int RowWords  = 64,
  parameter int PageRows  = 8,
  parameter int NumPages  = 2,
  parameter int OpLatency = 20,
  localparam int AddrW    = $clog2(NumPages * PageRows * RowWords)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regSel,
  input  logic [15:0]      regWdata,
  input  logic             tblWe,
  input  logic [AddrW-1:0] tblAddr,
  input  logic [WordW-1:0] tblWdata,
  output logic [15:0]      ctrlRead,
  output logic             stall,
  input  logic [AddrW-1:0] arrRdAddr,
  output logic [WordW-1:0] arrRdData
);

  nvmStrobe_t                     strobe;
  logic [RowWords-1:0][WordW-1:0] rowLatch;
  logic [AddrW-1:0]               tgtAddr;

  flash_nvm_ctrl #(.OpLatency(OpLatency)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .tblWe    (tblWe),
    .ctrlRead (ctrlRead),
    .busy     (stall),
    .strobe   (strobe)
  );

  flash_nvm_datapath #(.AddrW(AddrW), .RowWords(RowWords), .WordW(WordW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblWdata (tblWdata),
    .stall    (stall),
    .rowLatch (rowLatch),
    .tgtAddr  (tgtAddr)
  );

  flash_array_stub #(.NumPages(NumPages), .PageRows(PageRows),
                     .RowWords(RowWords), .WordW(WordW)) u_array (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tgtAddr  (tgtAddr),
    .rowLatch (rowLatch),
    .rdAddr   (arrRdAddr),
    .rdData   (arrRdData)
  );

endmodule

// File: tb/flash_nvm_top_tb.sv
`timescale 1ns/1ps
module flash_nvm_top_tb;

  localparam int Lat = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regSel = 1'b0;
  logic [15:0] regWdata = '0;
  logic        tblWe = 1'b0;
  logic [9:0]  tblAddr = '0;
  logic [23:0] tblWdata = '0;
  logic [15:0] ctrlRead;
  logic        stall;
  logic [9:0]  arrRdAddr = '0;
  logic [23:0] arrRdData;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  flash_nvm_top #(.OpLatency(Lat)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblWdata(tblWdata), .ctrlRead(ctrlRead),
    .stall(stall), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData)
  );

  // {key1, key2, control word, expected stall, expected error}
  localparam logic [33:0] VECS [8] = '{
    {8'h55, 8'hAA, 16'hC042, 1'b1, 1'b0},  // R3 erase start
    {8'h55, 8'hAA, 16'hC001, 1'b1, 1'b0},  // R3 program start
    {8'hAA, 8'h55, 16'hC042, 1'b0, 1'b0},  // R4 swapped keys
    {8'h55, 8'h56, 16'hC042, 1'b0, 1'b0},  // R4 wrong second key
    {8'h55, 8'hAA, 16'h8042, 1'b0, 1'b1},  // R9 write enable clear
    {8'h55, 8'hAA, 16'hC003, 1'b0, 1'b1},  // R9 undefined code
    {8'h55, 8'hAA, 16'hC002, 1'b0, 1'b1},  // R9 erase code, flag clear
    {8'h55, 8'hAA, 16'hC041, 1'b0, 1'b1}   // R9 program code, flag set
  };

  function automatic logic [23:0] pat(input int j);
    return 24'hA50000 | 24'(j * 3);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic tblWrite(input logic [9:0] a, input logic [23:0] d);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = a; tblWdata = d;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic unlock();
    regWrite(1'b1, 16'h0055);
    regWrite(1'b1, 16'h00AA);
  endtask

  task automatic readArr(input logic [9:0] a, output logic [23:0] d);
    arrRdAddr = a;
    #0.5;
    d = arrRdData;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [23:0] w;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ctrl", 32'(ctrlRead), 32'h0);
    check("R1 stall", 32'(stall), 32'h0);
    readArr(10'd0, w);    check("R1 arr0", 32'(w), 32'h0);
    readArr(10'd1023, w); check("R1 arrLast", 32'(w), 32'h0);

    // R2 field storage, reserved bits zero
    regWrite(1'b0, 16'h7FFF);
    check("R2 fields", 32'(ctrlRead), 32'h404F);

    // R8 row program into page 1 row 3, R6 stall length
    for (int j = 0; j < 64; j++) tblWrite(10'(704 + j), pat(j));
    unlock();
    regWrite(1'b0, 16'hC001);
    check("R3 start bit", 32'(ctrlRead[15]), 32'h1);
    waitIdle(n);
    check("R6 stall length", 32'(n), 32'(Lat));
    check("R6 start cleared", 32'(ctrlRead), 32'h4001);
    readArr(10'd704, w); check("R8 row first", 32'(w), 32'(pat(0)));
    readArr(10'd767, w); check("R8 row last", 32'(w), 32'(pat(63)));
    readArr(10'd703, w); check("R8 row below", 32'(w), 32'h0);
    readArr(10'd768, w); check("R8 row above", 32'(w), 32'h0);

    // R10 writes during stall ignored
    unlock();
    regWrite(1'b0, 16'hC001);
    regWrite(1'b1, 16'h0055);
    regWrite(1'b1, 16'h00AA);
    regWrite(1'b0, 16'h0000);
    tblWrite(10'd704, 24'h123456);
    check("R10 still stalled", 32'(stall), 32'h1);
    waitIdle(n);
    check("R10 ctrl kept", 32'(ctrlRead), 32'h4001);
    readArr(10'd704, w); check("R10 latch kept", 32'(w), 32'(pat(0)));
    regWrite(1'b0, 16'hC001);
    check("R11 no reuse of unlock", 32'(stall), 32'h0);

    // R7 page erase via dummy write into page 1
    tblWrite(10'd700, 24'h0);
    unlock();
    regWrite(1'b0, 16'hC042);
    waitIdle(n);
    readArr(10'd512, w);  check("R7 page start", 32'(w), 32'hFFFFFF);
    readArr(10'd1023, w); check("R7 page end", 32'(w), 32'hFFFFFF);
    readArr(10'd704, w);  check("R7 programmed row", 32'(w), 32'hFFFFFF);
    readArr(10'd511, w);  check("R7 other page", 32'(w), 32'h0);

    // R5 intervening writes cancel unlock
    unlock();
    tblWrite(10'd5, 24'h0);
    regWrite(1'b0, 16'hC042);
    check("R5 table write cancels", 32'(stall), 32'h0);
    check("R5 no error", 32'(ctrlRead[13]), 32'h0);
    unlock();
    regWrite(1'b0, 16'h4042);
    regWrite(1'b0, 16'hC042);
    check("R5 control write cancels", 32'(stall), 32'h0);

    // R4 doubled first key restarts sequence
    regWrite(1'b1, 16'h0055);
    unlock();
    regWrite(1'b0, 16'hC001);
    check("R4 doubled first key", 32'(stall), 32'h1);
    waitIdle(n);
    readArr(10'd0, w); check("R8 page0 row0", 32'(w), 32'(pat(0)));

    // R9 rejected start, sticky error, clear
    unlock();
    regWrite(1'b0, 16'h8042);
    check("R9 error readback", 32'(ctrlRead), 32'h2042);
    readArr(10'd0, w); check("R9 array untouched", 32'(w), 32'(pat(0)));
    regWrite(1'b0, 16'h0042);
    check("R9 error sticky", 32'(ctrlRead[13]), 32'h1);
    regWrite(1'b0, 16'h2000);
    check("R9 error cleared", 32'(ctrlRead), 32'h0);

    // vector table walk
    for (int v = 0; v < 8; v++) begin
      regWrite(1'b0, 16'h2000);
      regWrite(1'b1, {8'h00, VECS[v][33:26]});
      regWrite(1'b1, {8'h00, VECS[v][25:18]});
      regWrite(1'b0, VECS[v][17:2]);
      check($sformatf("R3/R4/R9 vec%0d stall", v), 32'(stall), 32'(VECS[v][1]));
      check($sformatf("R9 vec%0d error", v), 32'(ctrlRead[13]), 32'(VECS[v][0]));
      waitIdle(n);
      check($sformatf("R6 vec%0d cleared", v), 32'(ctrlRead[15]), 32'h0);
    end

    summary();
    $finish;
  end

endmodule